// File: doc/BRIEF.md
# Dual-Mode Core-to-Host Transmit Path

This block carries data words from a processor core toward an external host that reads them. The core writes into a one-word transmit holding register and watches a request flag that tells it when a write will be taken. The host samples a ready flag and pulses a read strobe to take the word shown on its read-data port.

A mode input selects one of two behaviours. With `fetch_mode` low (prefetch), words flow on their own from the transmit register through a small FIFO into a one-word host receive register, so data is staged ahead of host reads. With `fetch_mode` high (fetch), the FIFO is bypassed. The core is asked for a word only while the host signals an active read. At most one word is in flight, and the whole path is discarded as soon as the host stops reading. A format input (`wide_fmt`) halves the usable FIFO depth for wide-word operation.

Top module: `core_host_txpath`

## Requirements
- R1: While `rst` is high, `core_req` and `host_rdy` are low. After one reset edge `host_rdata` reads zero and every stage is empty.
- R2: A write taken while `core_req` is high makes `core_req` low on the next cycle. In prefetch mode, `core_req` returns high once the word has left the transmit register.
- R3: In prefetch mode, a word written into an empty path shows on `host_rdata` with `host_rdy` high after three clock edges. Words reach the host in the order they were written.
- R4: In prefetch mode the FIFO holds at most `DEPTH` words (6) when `wide_fmt`=0 and `DEPTH/2` words (3) when `wide_fmt`=1. With no host reads the path therefore accepts 8 or 5 words before `core_req` stays low.
- R5: `host_rdy` is high exactly when the receive register holds a word. A read strobe while `host_rdy` is high consumes that word.
- R6: A core write while `core_req` is low is dropped. A host read while `host_rdy` is low pops nothing, and `host_rdata` keeps its last value.
- R7: In fetch mode with `host_active` high, `core_req` is high only while no word is pending. A written word bypasses the FIFO and appears at the host after two edges.
- R8: In fetch mode, whenever `host_active` is low, both flags are low and any pending word is discarded at the next edge.
- R9: Any change of `fetch_mode` holds both flags low for that cycle and empties every stage at the next edge.
- R10: In fetch mode, each host read delivers at most one word. After the read, `host_rdy` is low and `core_req` is high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_mode | input | 1 | 1 = fetch (unbuffered), 0 = prefetch (FIFO) |
| wide_fmt | input | 1 | 1 = wide-word format, halves usable FIFO depth |
| core_wr | input | 1 | Core write strobe |
| core_wdata | input | W | Core write data |
| core_req | output | 1 | Core may write this cycle |
| host_active | input | 1 | Host read transfer in progress |
| host_rd | input | 1 | Host read strobe, consumes the shown word |
| host_rdata | output | W | Word presented to the host |
| host_rdy | output | 1 | Receive register holds a word |

## Verification
The assertions assume that `wide_fmt` changes only when the FIFO is empty, since a change while words are buffered is left undefined. They also assume that all inputs are held steady between clock edges. The stimulus meets the first assumption by draining the path with a run of reads before each format switch. It meets the second by driving every input once per cycle at the falling edge. `host_active` is exercised in held runs of random length, so fetch-mode flushes occur both with a word pending and with the path idle.

// File: rtl/txp_pkg.sv
package txp_pkg;

    localparam int DEF_WIDTH = 32;
    localparam int DEF_DEPTH = 6;

    typedef enum logic {
        PATH_PREFETCH = 1'b0,
        PATH_FETCH    = 1'b1
    } path_mode_e;

    // usable FIFO entries for the selected word format
    function automatic int usable_depth(input int depth, input logic wide);
        return wide ? depth / 2 : depth;
    endfunction

endpackage

// File: rtl/txp_slot.sv
module txp_slot #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flush,
    input  logic         load,
    input  logic         drain,
    input  logic [W-1:0] din,
    output logic         valid,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic         full;
        logic [W-1:0] word;
    } slot_t;

    slot_t cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else if (flush) begin
            cur.full <= 1'b0;
        end else if (load) begin
            cur.full <= 1'b1;
            cur.word <= din;
        end else if (drain) begin
            cur.full <= 1'b0;
        end
    end

    assign valid = cur.full;
    assign dout  = cur.word;
endmodule

// File: rtl/txp_ring.sv
module txp_ring #(
    parameter int W     = 32,
    parameter int DEPTH = 6,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  din,
    input  logic [CW-1:0] limit,
    output logic [CW-1:0] level,
    output logic [W-1:0]  head,
    output logic          has_space,
    output logic          nonempty
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp;
    logic [PW-1:0] rp;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (push) wp <= bump(wp);
            if (pop)  rp <= bump(rp);
            level <= level + CW'(push) - CW'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= din;
    end

    assign head      = mem[rp];
    assign has_space = (level < limit);
    assign nonempty  = (level != '0);
endmodule

// File: rtl/core_host_txpath.sv
module core_host_txpath
    import txp_pkg::*;
#(
    parameter int W     = DEF_WIDTH,
    parameter int DEPTH = DEF_DEPTH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         fetch_mode,
    input  logic         wide_fmt,
    input  logic         core_wr,
    input  logic [W-1:0] core_wdata,
    output logic         core_req,
    input  logic         host_active,
    input  logic         host_rd,
    output logic [W-1:0] host_rdata,
    output logic         host_rdy
);
    localparam int CW = $clog2(DEPTH + 1);

    path_mode_e    mode_now;
    path_mode_e    mode_prev;
    logic          mode_same;
    logic          in_fetch;
    logic          flush;

    logic          tx_v;
    logic [W-1:0]  tx_d;
    logic          rx_v;
    logic [W-1:0]  rx_d;

    logic          wr_take;
    logic          rd_take;
    logic          fifo_push;
    logic          fifo_pop;
    logic          rx_load;
    logic          tx_drain;
    logic [W-1:0]  rx_src;

    logic [CW-1:0] fifo_cap;
    logic [CW-1:0] fifo_level;
    logic [W-1:0]  fifo_head;
    logic          fifo_has_space;
    logic          fifo_nonempty;

    assign mode_now = path_mode_e'(fetch_mode);

    always_ff @(posedge clk) begin
        if (rst) mode_prev <= PATH_PREFETCH;
        else     mode_prev <= mode_now;
    end

    assign mode_same = (mode_now == mode_prev);
    assign in_fetch  = (mode_now == PATH_FETCH);
    // mode edge or an idle host in fetch mode discards the path
    assign flush     = !mode_same || (in_fetch && !host_active);

    assign core_req = !rst && mode_same &&
                      (in_fetch ? (host_active && !tx_v && !rx_v) : !tx_v);
    assign host_rdy = !rst && mode_same && rx_v && (!in_fetch || host_active);

    assign wr_take  = core_wr && core_req;
    assign rd_take  = host_rd && host_rdy;
    assign fifo_cap = CW'(usable_depth(DEPTH, wide_fmt));

    always_comb begin
        if (in_fetch) begin
            rx_load   = tx_v && !rx_v;
            rx_src    = tx_d;
            fifo_push = 1'b0;
        end else begin
            rx_load   = fifo_nonempty && (!rx_v || rd_take);
            rx_src    = fifo_head;
            fifo_push = tx_v && fifo_has_space;
        end
        fifo_pop = !in_fetch && rx_load;
        tx_drain = fifo_push || (in_fetch && rx_load);
    end

    txp_slot #(.W(W)) u_tx (
        .clk   (clk),
        .rst   (rst),
        .flush (flush),
        .load  (wr_take),
        .drain (tx_drain),
        .din   (core_wdata),
        .valid (tx_v),
        .dout  (tx_d)
    );

    txp_ring #(.W(W), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .push      (fifo_push),
        .pop       (fifo_pop),
        .din       (tx_d),
        .limit     (fifo_cap),
        .level     (fifo_level),
        .head      (fifo_head),
        .has_space (fifo_has_space),
        .nonempty  (fifo_nonempty)
    );

    txp_slot #(.W(W)) u_rx (
        .clk   (clk),
        .rst   (rst),
        .flush (flush),
        .load  (rx_load),
        .drain (rd_take),
        .din   (rx_src),
        .valid (rx_v),
        .dout  (rx_d)
    );

    assign host_rdata = rx_d;
endmodule

// File: rtl/core_host_txpath_chk.sv
module core_host_txpath_chk #(
    parameter int W     = 32,
    parameter int DEPTH = 6,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          fetch_mode,
    input logic          wide_fmt,
    input logic          core_wr,
    input logic          core_req,
    input logic          host_active,
    input logic          host_rd,
    input logic [W-1:0]  host_rdata,
    input logic          host_rdy,
    input logic [CW-1:0] fifo_level
);
    localparam logic [CW-1:0] LIM_NARROW = CW'(DEPTH);
    localparam logic [CW-1:0] LIM_WIDE   = CW'(DEPTH / 2);

    a_r1_rdy_low_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !host_rdy);

    a_r2_req_drops_on_write: assert property (@(posedge clk) disable iff (rst)
        (core_wr && core_req) |=> !core_req);

    a_r4_fifo_within_limit: assert property (@(posedge clk) disable iff (rst)
        fifo_level <= (wide_fmt ? LIM_WIDE : LIM_NARROW));

    a_r6_data_held: assert property (@(posedge clk) disable iff (rst)
        (host_rdy && !host_rd) |=> $stable(host_rdata));

    a_r8_fetch_idle_flags: assert property (@(posedge clk) disable iff (rst)
        (fetch_mode && !host_active) |-> (!core_req && !host_rdy));

    a_r10_one_word_per_read: assert property (@(posedge clk) disable iff (rst)
        (fetch_mode && host_rdy && host_rd) |=> !host_rdy);
endmodule

bind core_host_txpath core_host_txpath_chk #(.W(W), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/core_host_txpath_test.sv
`timescale 1ns/1ps
module core_host_txpath_test;
    localparam int W     = 32;
    localparam int DEPTH = 6;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         fetch_mode = 1'b0;
    logic         wide_fmt = 1'b0;
    logic         core_wr = 1'b0;
    logic [W-1:0] core_wdata = '0;
    logic         core_req;
    logic         host_active = 1'b0;
    logic         host_rd = 1'b0;
    logic [W-1:0] host_rdata;
    logic         host_rdy;

    always #4 clk = ~clk;

    core_host_txpath #(.W(W), .DEPTH(DEPTH)) uut (.*);

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic rst_req = 1'b1;

    // behavioural reference state
    bit           m_txv = 0;
    logic [W-1:0] m_txd = '0;
    logic [W-1:0] m_q[$];
    bit           m_rxv = 0;
    logic [W-1:0] m_rxd = '0;
    bit           m_prev = 0;

    logic [W-1:0] sent[$];
    logic [W-1:0] got[$];
    logic         obs_req, obs_rdy;
    logic [W-1:0] obs_data;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic wr, input logic [W-1:0] d, input logic rd,
                        input logic act, input logic md, input logic wf, input string tag);
        bit same, e_req, e_rdy, flush, pop, acc, rxload, push;
        int cap;
        logic [W-1:0] src;
        @(negedge clk);
        rst = rst_req; core_wr = wr; core_wdata = d; host_rd = rd;
        host_active = act; fetch_mode = md; wide_fmt = wf;
        #1;
        same  = (md == m_prev);
        cap   = wf ? DEPTH / 2 : DEPTH;
        e_req = !rst && same && (md ? (act && !m_txv && !m_rxv) : !m_txv);
        e_rdy = !rst && same && m_rxv && (!md || act);
        check(core_req === e_req, tag, "core_req", core_req, e_req);
        check(host_rdy === e_rdy, tag, "host_rdy", host_rdy, e_rdy);
        if (!rst) check(host_rdata === m_rxd, tag, "host_rdata", host_rdata, m_rxd);
        obs_req = core_req; obs_rdy = host_rdy; obs_data = host_rdata;
        acc = wr && e_req;
        pop = rd && e_rdy;
        if (acc) sent.push_back(d);
        if (pop) got.push_back(host_rdata);
        if (rst) begin
            m_txv = 0; m_rxv = 0; m_rxd = '0; m_q.delete(); m_prev = 0;
        end else begin
            flush = !same || (md && !act);
            m_prev = md;
            if (flush) begin
                m_txv = 0; m_rxv = 0; m_q.delete();
            end else begin
                if (md) begin
                    rxload = m_txv && !m_rxv; src = m_txd; push = 0;
                end else begin
                    rxload = (m_q.size() > 0) && (!m_rxv || pop);
                    src = (m_q.size() > 0) ? m_q[0] : '0;
                    push = m_txv && (m_q.size() < cap);
                end
                if (!md && rxload) void'(m_q.pop_front());
                if (push) m_q.push_back(m_txd);
                if (rxload) begin m_rxv = 1; m_rxd = src; end
                else if (pop) m_rxv = 0;
                if (acc) begin m_txv = 1; m_txd = d; end
                else if (push || (md && rxload)) m_txv = 0;
            end
        end
    endtask

    task automatic fill_and_drain(input logic wf, input int expect_acc, input string tag);
        sent.delete(); got.delete();
        for (int i = 0; i < 20; i++) step(1, W'(32'h100 + i), 0, 0, 0, wf, tag);
        check(sent.size() == expect_acc, "R4", "accepted words", sent.size(), expect_acc);
        check(obs_req == 0, "R4", "core_req when full", obs_req, 0);
        for (int i = 0; i < 30; i++) step(0, 0, 1, 0, 0, wf, "R5");
        check(got.size() == sent.size(), "R6", "words delivered", got.size(), sent.size());
        for (int i = 0; i < got.size(); i++)
            check(got[i] == sent[i], "R3", "delivery order", got[i], sent[i]);
    endtask

    initial begin
        // reset
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 0, "R1");
        check(obs_req == 0 && obs_rdy == 0, "R1", "flags in reset", {obs_req, obs_rdy}, 0);
        check(obs_data == 0, "R1", "data after reset", obs_data, 0);
        rst_req = 1'b0;
        step(0, 0, 0, 0, 0, 0, "R1");

        // prefetch latency, flag and hold behaviour
        step(1, 32'hA5, 0, 0, 0, 0, "R2");
        step(0, 0, 0, 0, 0, 0, "R2");
        check(obs_req == 0, "R2", "req after write", obs_req, 0);
        step(0, 0, 0, 0, 0, 0, "R3");
        check(obs_req == 1, "R2", "req after tx moved", obs_req, 1);
        check(obs_rdy == 0, "R3", "rdy before third edge", obs_rdy, 0);
        step(0, 0, 0, 0, 0, 0, "R3");
        check(obs_rdy == 1 && obs_data == 32'hA5, "R3", "word after three edges", obs_data, 32'hA5);
        step(0, 0, 1, 0, 0, 0, "R5");
        step(0, 0, 0, 0, 0, 0, "R5");
        check(obs_rdy == 0, "R5", "rdy after read", obs_rdy, 0);
        step(0, 0, 1, 0, 0, 0, "R6");
        step(0, 0, 0, 0, 0, 0, "R6");
        check(obs_rdy == 0 && obs_data == 32'hA5, "R6", "empty read keeps data", obs_data, 32'hA5);

        // capacity in both formats
        fill_and_drain(0, DEPTH + 2, "R4");
        fill_and_drain(1, DEPTH / 2 + 2, "R4");

        // random prefetch traffic
        for (int i = 0; i < 1500; i++)
            step(logic'($urandom_range(0, 1)), W'($urandom), logic'($urandom_range(0, 2) == 0),
                 logic'($urandom_range(0, 1)), 0, 0, "R5");

        // fetch mode directed
        step(0, 0, 0, 0, 1, 0, "R9");
        check(obs_req == 0 && obs_rdy == 0, "R9", "flags on mode change", {obs_req, obs_rdy}, 0);
        step(0, 0, 0, 1, 1, 0, "R7");
        check(obs_req == 1, "R7", "req on active read", obs_req, 1);
        step(1, 32'h77, 0, 1, 1, 0, "R7");
        step(0, 0, 0, 1, 1, 0, "R7");
        check(obs_req == 0 && obs_rdy == 0, "R2", "req after fetch write", obs_req, 0);
        step(0, 0, 0, 1, 1, 0, "R7");
        check(obs_rdy == 1 && obs_data == 32'h77, "R7", "bypass word after two edges", obs_data, 32'h77);
        step(0, 0, 1, 1, 1, 0, "R10");
        step(0, 0, 0, 1, 1, 0, "R10");
        check(obs_rdy == 0 && obs_req == 1, "R10", "one word per read", {obs_rdy, obs_req}, 1);
        step(1, 32'h88, 0, 1, 1, 0, "R8");
        step(0, 0, 0, 1, 1, 0, "R8");
        step(0, 0, 0, 0, 1, 0, "R8");
        check(obs_req == 0 && obs_rdy == 0, "R8", "flags when host idle", {obs_req, obs_rdy}, 0);
        step(0, 0, 0, 1, 1, 0, "R8");
        check(obs_req == 1 && obs_rdy == 0, "R8", "pending word discarded", {obs_req, obs_rdy}, 2);

        // random fetch traffic with held host_active runs
        begin
            logic a = 1'b1;
            for (int i = 0; i < 1500; i++) begin
                if ($urandom_range(0, 7) == 0) a = ~a;
                step(logic'($urandom_range(0, 1)), W'($urandom), logic'($urandom_range(0, 1)),
                     a, 1, 0, "R7");
            end
        end

        // back to prefetch with a word pending
        step(1, 32'h99, 0, 1, 1, 0, "R9");
        step(0, 0, 0, 1, 1, 0, "R9");
        step(0, 0, 0, 1, 0, 0, "R9");
        check(obs_req == 0 && obs_rdy == 0, "R9", "flags on return to prefetch", {obs_req, obs_rdy}, 0);
        step(0, 0, 0, 1, 0, 0, "R9");
        check(obs_req == 1 && obs_rdy == 0, "R9", "path empty after change", {obs_req, obs_rdy}, 2);
        for (int i = 0; i < 4; i++) step(0, 0, 0, 1, 0, 0, "R9");
        check(obs_rdy == 0, "R9", "discarded word stays gone", obs_rdy, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule